// File: doc/BRIEF.md
# Load-Store Register and ALU Datapath

This block is the data side of a small load-store processor. A separate controller decodes instructions and drives every control input. The block holds a sixteen-entry register file with two combinational read ports and one clocked write port. It has an ALU that adds or subtracts the two read operands, and a word-wide data memory of 256 entries modelled internally. A write-back selector chooses what the register file receives: a memory word, the ALU result, or a zero-extended 8-bit constant.

Each cycle the controller asks for one kind of work:

- a load, which moves a memory word into a register;
- an ALU operation, which combines two registers and writes the result back;
- a store, which copies read port A into memory.

The ALU never sees memory directly. The block also raises a flag when the register on read port A holds zero. The controller uses this flag to decide a conditional jump.

Write-back select codes (`wb_sel`):

| Code | Name | Register file receives |
|------|------|------------------------|
| 2'b00 | WB_MEM | data-memory word at `dm_addr` |
| 2'b01 | WB_ALU | ALU result |
| 2'b10 | WB_IMM | `imm` zero-extended |
| 2'b11 | WB_ZERO | zero |

The block has no state machine of its own. These four codes are the only modes it distinguishes. There are no states and no transitions between them.

Top module: `lsdp_top`

## Requirements
- R1: While `rst_n` is low, every register and every memory word is cleared to zero. After release, every register reads 0 and every memory word loads as 0.
- R2: `rdata_a` and `rdata_b` show the registers addressed by `rf_raddr_a` and `rf_raddr_b` in the same cycle, with no clock edge in between.
- R3: With `rf_we` low, a rising edge changes no register, whatever the other write-back inputs are.
- R4: With `rf_we` high and `wb_sel` = 2'b00, the register at `rf_waddr` takes the memory word at `dm_addr` on the rising edge.
- R5: With `rf_we` high, `wb_sel` = 2'b01 and `alu_sub` low, the register at `rf_waddr` takes `rdata_a + rdata_b` modulo 2^16.
- R6: With `rf_we` high, `wb_sel` = 2'b01 and `alu_sub` high, the register at `rf_waddr` takes `rdata_a - rdata_b` modulo 2^16.
- R7: With `rf_we` high and `wb_sel` = 2'b10, the register at `rf_waddr` takes `imm` in bits 7:0, with zeros in bits 15:8.
- R8: With `dm_we` high, the memory word at `dm_addr` takes `rdata_a` on the rising edge. `mem_addr_o`, `mem_wdata_o` and `mem_we_o` show `dm_addr`, `rdata_a` and `dm_we` in the same cycle.
- R9: `a_zero` is high exactly when the register on read port A holds 0.
- R10: With `rf_we` high and `wb_sel` = 2'b11, the register at `rf_waddr` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | 4 | Register write address |
| rf_raddr_a | input | 4 | Read port A address (ALU first operand, store source, zero test) |
| rf_raddr_b | input | 4 | Read port B address (ALU second operand) |
| wb_sel | input | 2 | Write-back source code |
| alu_sub | input | 1 | 1 = subtract, 0 = add |
| imm | input | 8 | Constant for write-back |
| dm_addr | input | 8 | Data-memory address for load and store |
| dm_we | input | 1 | Data-memory write enable |
| rdata_a | output | 16 | Read port A data |
| rdata_b | output | 16 | Read port B data |
| a_zero | output | 1 | Read port A register equals zero |
| mem_addr_o | output | 8 | Memory address being driven |
| mem_wdata_o | output | 16 | Memory write data being driven |
| mem_we_o | output | 1 | Memory write enable being driven |

## Verification
The outputs fall into two timing groups:

- Same-cycle results: the read data, the zero flag and the three memory-port outputs depend only on the current inputs and the stored state. They are due in the same cycle as the stimulus.
- One-edge results: a register write or a memory write becomes visible one rising edge after the cycle that requested it.

The bench changes the inputs at the falling edge and compares the same-cycle results 1 ns later. It then lets the rising edge commit the write and updates its own register and memory model. Every later read therefore tests the earlier write exactly one edge afterwards. Memory contents are observed through loads, so a store is confirmed two edges after it was requested.

// File: rtl/lsdp_pkg.sv
package lsdp_pkg;

    // Write-back source selection, encoding fixed by the controller interface
    typedef enum logic [1:0] {
        WB_MEM  = 2'b00,
        WB_ALU  = 2'b01,
        WB_IMM  = 2'b10,
        WB_ZERO = 2'b11
    } wb_sel_t;

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alu_op_t;

endpackage

// File: rtl/lsdp_regfile.sv
module lsdp_regfile #(
    parameter int DATA_W  = 16,
    parameter int RADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [RADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [RADDR_W-1:0] raddr_a,
    input  logic [RADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0]  rdata_a,
    output logic [DATA_W-1:0]  rdata_b
);
    localparam int NREG = 1 << RADDR_W;

    logic [DATA_W-1:0] regs [NREG];

    // One storage process per entry; each entry decodes its own write strobe
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic hit;
        assign hit = we && (waddr == RADDR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (hit) begin
                regs[g] <= wdata;
            end
        end
    end

    // Combinational read ports
    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/lsdp_alu.sv
module lsdp_alu
    import lsdp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result
);
    // Wrap-around arithmetic; carry and borrow are discarded
    always_comb begin
        unique case (op)
            ALU_ADD: result = opa + opb;
            ALU_SUB: result = opa - opb;
        endcase
    end

endmodule

// File: rtl/lsdp_wbmux.sv
module lsdp_wbmux
    import lsdp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8
) (
    input  wb_sel_t           sel,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] alu_word,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] wdata
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    assign imm_ext = {{PAD_W{1'b0}}, imm};

    always_comb begin
        unique case (sel)
            WB_MEM:  wdata = mem_word;
            WB_ALU:  wdata = alu_word;
            WB_IMM:  wdata = imm_ext;
            WB_ZERO: wdata = '0;
        endcase
    end

endmodule

// File: rtl/lsdp_dmem.sv
module lsdp_dmem #(
    parameter int DATA_W  = 16,
    parameter int DADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [DADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    localparam int NWORD = 1 << DADDR_W;

    logic [DATA_W-1:0] mem [NWORD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORD; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Asynchronous read: a load completes within its own cycle
    assign rdata = mem[addr];

endmodule

// File: rtl/lsdp_top.sv
module lsdp_top
    import lsdp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int RADDR_W = 4,
    parameter int DADDR_W = 8,
    parameter int IMM_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rf_we,
    input  logic [RADDR_W-1:0] rf_waddr,
    input  logic [RADDR_W-1:0] rf_raddr_a,
    input  logic [RADDR_W-1:0] rf_raddr_b,
    input  logic [1:0]         wb_sel,
    input  logic               alu_sub,
    input  logic [IMM_W-1:0]   imm,
    input  logic [DADDR_W-1:0] dm_addr,
    input  logic               dm_we,
    output logic [DATA_W-1:0]  rdata_a,
    output logic [DATA_W-1:0]  rdata_b,
    output logic               a_zero,
    output logic [DADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    output logic               mem_we_o
);
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] mem_rd;
    logic [DATA_W-1:0] wb_data;

    wb_sel_t sel_q;
    alu_op_t op_q;

    assign sel_q = wb_sel_t'(wb_sel);
    assign op_q  = alu_op_t'(alu_sub);

    lsdp_regfile #(
        .DATA_W  (DATA_W),
        .RADDR_W (RADDR_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (wb_data),
        .raddr_a (rf_raddr_a),
        .raddr_b (rf_raddr_b),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b)
    );

    lsdp_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op     (op_q),
        .opa    (rdata_a),
        .opb    (rdata_b),
        .result (alu_res)
    );

    lsdp_dmem #(
        .DATA_W  (DATA_W),
        .DADDR_W (DADDR_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dm_we),
        .addr  (dm_addr),
        .wdata (rdata_a),
        .rdata (mem_rd)
    );

    lsdp_wbmux #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_wb (
        .sel      (sel_q),
        .mem_word (mem_rd),
        .alu_word (alu_res),
        .imm      (imm),
        .wdata    (wb_data)
    );

    assign a_zero      = (rdata_a == '0);
    assign mem_addr_o  = dm_addr;
    assign mem_wdata_o = rdata_a;
    assign mem_we_o    = dm_we;

endmodule

// File: rtl/lsdp_checker.sv
module lsdp_checker #(
    parameter int DATA_W  = 16,
    parameter int RADDR_W = 4,
    parameter int IMM_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rf_we,
    input logic [RADDR_W-1:0] rf_waddr,
    input logic [RADDR_W-1:0] rf_raddr_a,
    input logic [1:0]         wb_sel,
    input logic               alu_sub,
    input logic [IMM_W-1:0]   imm,
    input logic [DATA_W-1:0]  rdata_a,
    input logic [DATA_W-1:0]  rdata_b,
    input logic               a_zero
);
    localparam int PAD_W = DATA_W - IMM_W;

    // R3: without a write, a port A read of the same address is unchanged
    a_r3_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_we |=> (rf_raddr_a != $past(rf_raddr_a)) || (rdata_a == $past(rdata_a)));

    // R5: an add write-back shows up on port A one edge later
    a_r5_add_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && wb_sel == 2'b01 && !alu_sub)
        |=> (rf_raddr_a != $past(rf_waddr)) || (rdata_a == $past(rdata_a + rdata_b)));

    // R6: a subtract write-back shows up on port A one edge later
    a_r6_sub_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && wb_sel == 2'b01 && alu_sub)
        |=> (rf_raddr_a != $past(rf_waddr)) || (rdata_a == $past(rdata_a - rdata_b)));

    // R7: a constant write-back is zero-extended
    a_r7_imm_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && wb_sel == 2'b10)
        |=> (rf_raddr_a != $past(rf_waddr)) || (rdata_a == {{PAD_W{1'b0}}, $past(imm)}));

    // R9: writing zero raises the flag when that register is read on port A
    a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && (wb_sel == 2'b11 || (wb_sel == 2'b10 && imm == '0)))
        |=> (rf_raddr_a != $past(rf_waddr)) || a_zero);

endmodule

bind lsdp_top lsdp_checker #(
    .DATA_W  (DATA_W),
    .RADDR_W (RADDR_W),
    .IMM_W   (IMM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_raddr_a (rf_raddr_a),
    .wb_sel     (wb_sel),
    .alu_sub    (alu_sub),
    .imm        (imm),
    .rdata_a    (rdata_a),
    .rdata_b    (rdata_b),
    .a_zero     (a_zero)
);

// File: tb/lsdp_top_test.sv
`timescale 1ns/1ps
module lsdp_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rf_we;
    logic [3:0]  rf_waddr, rf_raddr_a, rf_raddr_b;
    logic [1:0]  wb_sel;
    logic        alu_sub;
    logic [7:0]  imm, dm_addr;
    logic        dm_we;
    logic [15:0] rdata_a, rdata_b, mem_wdata_o;
    logic        a_zero, mem_we_o;
    logic [7:0]  mem_addr_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] rf_m  [16];
    logic [15:0] mem_m [256];
    logic [3:0]  prev;

    always #5 clk = ~clk;

    lsdp_top uut (
        .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b), .wb_sel(wb_sel),
        .alu_sub(alu_sub), .imm(imm), .dm_addr(dm_addr), .dm_we(dm_we),
        .rdata_a(rdata_a), .rdata_b(rdata_b), .a_zero(a_zero),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, check same-cycle outputs, commit at the rising edge
    task automatic step(input logic we, input logic [3:0] wa, input logic [3:0] ra,
                        input logic [3:0] rb, input logic [1:0] sel, input logic sub,
                        input logic [7:0] im, input logic [7:0] da, input logic dwe,
                        input string tag);
        logic [15:0] wv;
        @(negedge clk);
        rf_we = we; rf_waddr = wa; rf_raddr_a = ra; rf_raddr_b = rb;
        wb_sel = sel; alu_sub = sub; imm = im; dm_addr = da; dm_we = dwe;
        #1;
        check(rdata_a == rf_m[ra], tag, rdata_a, rf_m[ra]);
        check(rdata_b == rf_m[rb], "R2", rdata_b, rf_m[rb]);
        check(a_zero == (rf_m[ra] == 16'h0), "R9", {15'h0, a_zero}, {15'h0, rf_m[ra] == 16'h0});
        check(mem_addr_o == da && mem_we_o == dwe, "R8", {7'h0, mem_we_o, mem_addr_o}, {7'h0, dwe, da});
        check(mem_wdata_o == rf_m[ra], "R8", mem_wdata_o, rf_m[ra]);
        case (sel)
            2'b00:   wv = mem_m[da];
            2'b01:   wv = sub ? rf_m[ra] - rf_m[rb] : rf_m[ra] + rf_m[rb];
            2'b10:   wv = {8'h00, im};
            default: wv = 16'h0000;
        endcase
        @(posedge clk);
        if (dwe) mem_m[da] = rf_m[ra];
        if (we)  rf_m[wa]  = wv;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++)  rf_m[i]  = 16'h0;
        for (int i = 0; i < 256; i++) mem_m[i] = 16'h0;
        rst_n = 1'b0; rf_we = 0; rf_waddr = 0; rf_raddr_a = 0; rf_raddr_b = 0;
        wb_sel = 0; alu_sub = 0; imm = 0; dm_addr = 0; dm_we = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: registers cleared
        for (int i = 0; i < 16; i++)
            step(0, 4'(i), 4'(i), 4'(15 - i), 2'b10, 0, 8'h5A, 8'h00, 0, "R1");
        // R1 / R4: every memory word loads as zero
        prev = 0;
        for (int a = 0; a < 256; a++) begin
            step(1, 4'(a), prev, 4'(a + 3), 2'b00, 0, 8'h00, 8'(a), 0, "R4");
            prev = 4'(a);
        end
        // R7: constants, including all-ones and zero
        for (int i = 0; i < 16; i++) begin
            step(1, 4'(i), prev, 4'(i), 2'b10, 0,
                 (i == 3) ? 8'hFF : (i == 5) ? 8'h00 : 8'((i * 53 + 11) & 255),
                 8'h00, 0, "R7");
            prev = 4'(i);
        end
        // R5 / R6: every operand pair, add or subtract, wrapping values accumulate
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1, 4'(a + b + 1), 4'(a), 4'(b), 2'b01, ((a + b) % 2) == 0,
                     8'h00, 8'h00, 0, (((a + b) % 2) == 0) ? "R6" : "R5");
            end
        end
        // R3: suppressed writes leave every register untouched
        for (int i = 0; i < 16; i++)
            step(0, 4'(i), 4'(i), 4'(i), 2'b10, 0, 8'hAA, 8'h00, 0, "R3");
        for (int i = 0; i < 16; i++)
            step(0, 4'(i), 4'(i), 4'(i), 2'b01, 1, 8'h00, 8'h00, 0, "R3");
        // R10: zero code clears a register
        step(1, 4'd4, 4'd4, 4'd0, 2'b11, 0, 8'h77, 8'h00, 0, "R2");
        step(0, 4'd0, 4'd4, 4'd4, 2'b10, 0, 8'h00, 8'h00, 0, "R10");
        // R8: store every address from varying registers
        for (int a = 0; a < 256; a++)
            step(0, 4'd0, 4'(a * 5), 4'(a), 2'b00, 0, 8'h00, 8'(a), 1, "R8");
        // R4: load every address back
        prev = 0;
        for (int a = 0; a < 256; a++) begin
            step(1, 4'(a * 3), prev, 4'(a), 2'b00, 0, 8'h00, 8'(a), 0, "R4");
            prev = 4'(a * 3);
        end
        step(0, 4'd0, prev, 4'd1, 2'b00, 0, 8'h00, 8'h00, 0, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule